// File: doc/BRIEF.md
# Upscaling VGA Framebuffer Scanout

This block produces the raster timing for a 1024x768 display refreshed at 60 Hz and fills part of that raster from a small 256x128 image store. Each stored pixel is repeated four times across and four times down, so the image occupies a 1024x512 window that starts at the top-left corner of the visible area. Everything outside that window, and all of the blanking intervals, is driven black. The colour output is twelve bits, four per channel, each channel meant for an external resistor-ladder converter, and it is accompanied by separate active-low horizontal and vertical sync lines.

The block does not own the image memory. It presents a read address, derived from the current raster position, to a synchronous memory that answers one pixel-clock later, and it lines the returned colour up with the matching sync state. All logic runs from one system clock qualified by a pixel-clock enable (nominally 65 MHz of enables). The renderer that fills the memory runs at half the display rate, and the block gives it a one-clock pulse at the start of vertical blanking on every second frame so that each finished image is shown on exactly two consecutive display frames.

Defaults are the standard XGA timing: 1024 visible, 24 front porch, 136 sync, 160 back porch per line (1344 clocks); 768 visible, 3 front porch, 6 sync, 29 back porch lines per frame (806 lines). All timing, buffer and scale figures are parameters.

Top module: `vga_upscale_scanout`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP enabled pixel clocks; within it, vga_hs_n is low for exactly H_SYNC positions starting at column H_ACTIVE+H_FP and high everywhere else.
- R2: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines; vga_vs_n is low for every position of lines V_ACTIVE+V_FP through V_ACTIVE+V_FP+V_SYNC-1 and high on all other lines.
- R3: After the k-th enabled edge since reset the scan position is k modulo the frame length, counted line by line from column 0 of line 0; fb_addr for that position is {line>>SCALE_LOG2 (FB_YW bits), column>>SCALE_LOG2 (FB_XW bits)}, the memory returns fb_data one enabled edge later, and the colour and both syncs of position p appear together at the outputs two enabled edges after the scan reaches p. fb_data bits 11:8 are red, 7:4 green, 3:0 blue.
- R4: Every stored pixel is shown on a block of 2^SCALE_LOG2 by 2^SCALE_LOG2 display pixels (4x4 by default); neighbouring blocks show neighbouring stored pixels.
- R5: All twelve colour bits are zero during horizontal and vertical blanking, in visible columns at or beyond the window width, and on visible lines at or beyond the window height (lines 512 to 767 by default).
- R6: frame_tick is high for exactly one clock, on the enabled edge at which the scan enters the first blanking line (line V_ACTIVE, column 0), and only on every second such entry counting from reset: the entries of frames 1, 3, 5 and so on, frame 0 being the first after reset.
- R7: When pix_ce is low, the scan position, fb_addr, the colour and sync outputs hold their values and frame_tick stays low.
- R8: Synchronous active-high reset returns the scan to line 0, column 0 (fb_addr 0), drives both syncs high, the colour to zero and frame_tick low, and restarts the frame pairing so that the next tick comes at the end of frame 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_ce | input | 1 | Pixel-clock enable; one raster position per enabled edge |
| fb_addr | output | FB_XW+FB_YW (15) | Read address to the image memory, {row, column} |
| fb_data | input | 12 | Pixel word returned by the memory one enabled edge after the address |
| vga_red | output | 4 | Red level |
| vga_grn | output | 4 | Green level |
| vga_blu | output | 4 | Blue level |
| vga_hs_n | output | 1 | Horizontal sync, active low |
| vga_vs_n | output | 1 | Vertical sync, active low |
| frame_tick | output | 1 | One-clock pulse at vertical blanking start of every second frame |

## Verification
The hardest behaviour to reach is the pairing of frames for the renderer pulse, since at full XGA timing a single frame runs over a million enabled clocks and the second-frame tick sits beyond any sensible run length. The bench therefore builds the block with shrunk raster and buffer parameters, keeping the window narrower than the visible line and shorter than the visible frame so every region exists, and runs four frames at full enable to see the first and second ticks. It then gates the enable on alternate clocks across a tick to show the hold behaviour, and resets mid-frame to show that the pairing restarts and the first frame after reset stays silent.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

    // Default raster: 1024x768 at 60 Hz, 65 MHz nominal pixel enable.
    localparam int DEF_H_ACTIVE   = 1024;
    localparam int DEF_H_FP       = 24;
    localparam int DEF_H_SYNC     = 136;
    localparam int DEF_H_BP       = 160;
    localparam int DEF_V_ACTIVE   = 768;
    localparam int DEF_V_FP       = 3;
    localparam int DEF_V_SYNC     = 6;
    localparam int DEF_V_BP       = 29;

    // Default image store: 256 columns by 128 rows, each shown 4x4.
    localparam int DEF_FB_XW      = 8;
    localparam int DEF_FB_YW      = 7;
    localparam int DEF_SCALE_LOG2 = 2;

    localparam int PIX_W          = 12;

    typedef struct packed {
        logic [3:0] red;
        logic [3:0] grn;
        logic [3:0] blu;
    } rgb12_t;

    // Per-position control carried down the fetch pipeline.
    typedef struct packed {
        logic vis;   // inside the visible raster
        logic win;   // inside the upscaled image window
        logic hs_n;
        logic vs_n;
    } scan_ctl_t;

    localparam scan_ctl_t CTL_IDLE = '{vis: 1'b0, win: 1'b0, hs_n: 1'b1, vs_n: 1'b1};

    localparam rgb12_t RGB_BLACK = '{red: 4'h0, grn: 4'h0, blu: 4'h0};

    function automatic rgb12_t word_to_rgb(input logic [PIX_W-1:0] w);
        rgb12_t c;
        c.red = w[11:8];
        c.grn = w[7:4];
        c.blu = w[3:0];
        return c;
    endfunction

    function automatic logic in_span(input int unsigned pos,
                                     input int unsigned lo,
                                     input int unsigned len);
        return (pos >= lo) && (pos < lo + len);
    endfunction

endpackage

// File: rtl/vgs_raster_timer.sv
module vgs_raster_timer
    import vgs_pkg::*;
#(
    parameter int H_ACTIVE = DEF_H_ACTIVE,
    parameter int H_FP     = DEF_H_FP,
    parameter int H_SYNC   = DEF_H_SYNC,
    parameter int H_BP     = DEF_H_BP,
    parameter int V_ACTIVE = DEF_V_ACTIVE,
    parameter int V_FP     = DEF_V_FP,
    parameter int V_SYNC   = DEF_V_SYNC,
    parameter int V_BP     = DEF_V_BP,
    parameter int HCW      = 11,
    parameter int VCW      = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce,
    output logic [HCW-1:0] h_cnt,
    output logic [VCW-1:0] v_cnt,
    output logic           vis,
    output logic           hs_n,
    output logic           vs_n,
    output logic           enter_vblank
);

    localparam int unsigned H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int unsigned V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int unsigned HS_START = H_ACTIVE + H_FP;
    localparam int unsigned VS_START = V_ACTIVE + V_FP;

    localparam logic [HCW-1:0] H_LAST      = HCW'(H_TOTAL - 1);
    localparam logic [VCW-1:0] V_LAST      = VCW'(V_TOTAL - 1);
    localparam logic [VCW-1:0] V_PRE_BLANK = VCW'(V_ACTIVE - 1);

    logic end_of_line;

    assign end_of_line = (h_cnt == H_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (ce) begin
            if (end_of_line) begin
                h_cnt <= '0;
                v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
            end else begin
                h_cnt <= h_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        vis  = (32'(h_cnt) < H_ACTIVE) && (32'(v_cnt) < V_ACTIVE);
        hs_n = !in_span(32'(h_cnt), HS_START, H_SYNC);
        vs_n = !in_span(32'(v_cnt), VS_START, V_SYNC);
    end

    // The enabled edge that moves the scan onto the first blanking line.
    assign enter_vblank = ce && end_of_line && (v_cnt == V_PRE_BLANK);

endmodule

// File: rtl/vgs_fetch_addr.sv
module vgs_fetch_addr
    import vgs_pkg::*;
#(
    parameter int FB_XW      = DEF_FB_XW,
    parameter int FB_YW      = DEF_FB_YW,
    parameter int SCALE_LOG2 = DEF_SCALE_LOG2,
    parameter int H_ACTIVE   = DEF_H_ACTIVE,
    parameter int V_ACTIVE   = DEF_V_ACTIVE,
    parameter int HCW        = 11,
    parameter int VCW        = 10
) (
    input  logic [HCW-1:0]         h_cnt,
    input  logic [VCW-1:0]         v_cnt,
    output logic [FB_XW+FB_YW-1:0] fb_addr,
    output logic                   in_win
);

    localparam int unsigned WIN_W = 1 << (FB_XW + SCALE_LOG2);
    localparam int unsigned WIN_H = 1 << (FB_YW + SCALE_LOG2);

    logic x_ok;
    logic y_ok;

    // Power-of-two replication: dropping the low bits of each counter
    // repeats every stored pixel over a square block of display pixels.
    assign fb_addr = {v_cnt[SCALE_LOG2 +: FB_YW], h_cnt[SCALE_LOG2 +: FB_XW]};

    generate
        if (WIN_W >= H_ACTIVE) begin : g_x_full
            assign x_ok = 1'b1;
        end else begin : g_x_clip
            assign x_ok = (32'(h_cnt) < WIN_W);
        end

        if (WIN_H >= V_ACTIVE) begin : g_y_full
            assign y_ok = 1'b1;
        end else begin : g_y_clip
            assign y_ok = (32'(v_cnt) < WIN_H);
        end
    endgenerate

    assign in_win = x_ok && y_ok;

endmodule

// File: rtl/vgs_pixel_out.sv
module vgs_pixel_out
    import vgs_pkg::*;
#(
    parameter int FETCH_LAT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  scan_ctl_t        ctl_now,
    input  logic [PIX_W-1:0] fb_data,
    output rgb12_t           pix,
    output logic             hs_n,
    output logic             vs_n
);

    // Control for each position waits here while its pixel word is read.
    scan_ctl_t pipe [FETCH_LAT];
    scan_ctl_t lead;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FETCH_LAT; i++) begin
                pipe[i] <= CTL_IDLE;
            end
        end else if (ce) begin
            pipe[0] <= ctl_now;
            for (int i = 1; i < FETCH_LAT; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign lead = pipe[FETCH_LAT-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pix  <= RGB_BLACK;
            hs_n <= 1'b1;
            vs_n <= 1'b1;
        end else if (ce) begin
            hs_n <= lead.hs_n;
            vs_n <= lead.vs_n;
            pix  <= (lead.vis && lead.win) ? word_to_rgb(fb_data) : RGB_BLACK;
        end
    end

endmodule

// File: rtl/vgs_frame_pacer.sv
module vgs_frame_pacer #(
    parameter int RATE_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enter_vblank,
    output logic frame_tick
);

    generate
        if (RATE_DIV <= 1) begin : g_every
            always_ff @(posedge clk) begin
                if (rst) frame_tick <= 1'b0;
                else     frame_tick <= enter_vblank;
            end
        end else begin : g_divide
            localparam int CW = $clog2(RATE_DIV);
            localparam logic [CW-1:0] PH_LAST = CW'(RATE_DIV - 1);

            logic [CW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst) begin
                    phase      <= '0;
                    frame_tick <= 1'b0;
                end else begin
                    frame_tick <= 1'b0;
                    if (enter_vblank) begin
                        if (phase == PH_LAST) begin
                            phase      <= '0;
                            frame_tick <= 1'b1;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vga_upscale_scanout.sv
module vga_upscale_scanout
    import vgs_pkg::*;
#(
    parameter int H_ACTIVE   = DEF_H_ACTIVE,
    parameter int H_FP       = DEF_H_FP,
    parameter int H_SYNC     = DEF_H_SYNC,
    parameter int H_BP       = DEF_H_BP,
    parameter int V_ACTIVE   = DEF_V_ACTIVE,
    parameter int V_FP       = DEF_V_FP,
    parameter int V_SYNC     = DEF_V_SYNC,
    parameter int V_BP       = DEF_V_BP,
    parameter int FB_XW      = DEF_FB_XW,
    parameter int FB_YW      = DEF_FB_YW,
    parameter int SCALE_LOG2 = DEF_SCALE_LOG2,
    parameter int FETCH_LAT  = 1,
    parameter int RATE_DIV   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pix_ce,
    output logic [FB_XW+FB_YW-1:0] fb_addr,
    input  logic [11:0]            fb_data,
    output logic [3:0]             vga_red,
    output logic [3:0]             vga_grn,
    output logic [3:0]             vga_blu,
    output logic                   vga_hs_n,
    output logic                   vga_vs_n,
    output logic                   frame_tick
);

    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HCW     = $clog2(H_TOTAL);
    localparam int VCW     = $clog2(V_TOTAL);

    logic [HCW-1:0] h_cnt;
    logic [VCW-1:0] v_cnt;
    logic           ras_vis;
    logic           ras_hs_n;
    logic           ras_vs_n;
    logic           enter_vblank;
    logic           in_win;
    scan_ctl_t      ctl_now;
    rgb12_t         pix;

    vgs_raster_timer #(
        .H_ACTIVE (H_ACTIVE),
        .H_FP     (H_FP),
        .H_SYNC   (H_SYNC),
        .H_BP     (H_BP),
        .V_ACTIVE (V_ACTIVE),
        .V_FP     (V_FP),
        .V_SYNC   (V_SYNC),
        .V_BP     (V_BP),
        .HCW      (HCW),
        .VCW      (VCW)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .ce           (pix_ce),
        .h_cnt        (h_cnt),
        .v_cnt        (v_cnt),
        .vis          (ras_vis),
        .hs_n         (ras_hs_n),
        .vs_n         (ras_vs_n),
        .enter_vblank (enter_vblank)
    );

    vgs_fetch_addr #(
        .FB_XW      (FB_XW),
        .FB_YW      (FB_YW),
        .SCALE_LOG2 (SCALE_LOG2),
        .H_ACTIVE   (H_ACTIVE),
        .V_ACTIVE   (V_ACTIVE),
        .HCW        (HCW),
        .VCW        (VCW)
    ) u_fetch (
        .h_cnt   (h_cnt),
        .v_cnt   (v_cnt),
        .fb_addr (fb_addr),
        .in_win  (in_win)
    );

    assign ctl_now = '{vis: ras_vis, win: in_win, hs_n: ras_hs_n, vs_n: ras_vs_n};

    vgs_pixel_out #(
        .FETCH_LAT (FETCH_LAT)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .ce      (pix_ce),
        .ctl_now (ctl_now),
        .fb_data (fb_data),
        .pix     (pix),
        .hs_n    (vga_hs_n),
        .vs_n    (vga_vs_n)
    );

    vgs_frame_pacer #(
        .RATE_DIV (RATE_DIV)
    ) u_pacer (
        .clk          (clk),
        .rst          (rst),
        .enter_vblank (enter_vblank),
        .frame_tick   (frame_tick)
    );

    assign vga_red = pix.red;
    assign vga_grn = pix.grn;
    assign vga_blu = pix.blu;

endmodule

// File: rtl/vgs_scanout_checker.sv
module vgs_scanout_checker #(
    parameter int HCW      = 11,
    parameter int VCW      = 10,
    parameter int H_TOTAL  = 1344,
    parameter int V_TOTAL  = 806,
    parameter int V_ACTIVE = 768
) (
    input logic           clk,
    input logic           rst,
    input logic           pix_ce,
    input logic [HCW-1:0] h_cnt,
    input logic [VCW-1:0] v_cnt,
    input logic           vga_hs_n,
    input logic           vga_vs_n,
    input logic [11:0]    rgb,
    input logic           frame_tick
);

    localparam logic [HCW-1:0] H_LAST   = HCW'(H_TOTAL - 1);
    localparam logic [VCW-1:0] V_LAST   = VCW'(V_TOTAL - 1);
    localparam logic [VCW-1:0] V_BLANK0 = VCW'(V_ACTIVE);

    assert_line_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (pix_ce && h_cnt == H_LAST) |=> (h_cnt == '0));

    assert_col_range_R1: assert property (@(posedge clk) disable iff (rst)
        h_cnt <= H_LAST);

    assert_line_range_R2: assert property (@(posedge clk) disable iff (rst)
        v_cnt <= V_LAST);

    assert_dark_in_sync_R5: assert property (@(posedge clk) disable iff (rst)
        (!vga_hs_n || !vga_vs_n) |-> (rgb == 12'h000));

    assert_tick_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> !frame_tick);

    assert_tick_place_R6: assert property (@(posedge clk) disable iff (rst)
        frame_tick |-> (v_cnt == V_BLANK0 && h_cnt == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !pix_ce |=> ($stable(h_cnt) && $stable(v_cnt) && $stable(rgb)
                     && $stable(vga_hs_n) && $stable(vga_vs_n) && !frame_tick));

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (h_cnt == '0 && v_cnt == '0 && vga_hs_n && vga_vs_n
                        && rgb == 12'h000 && !frame_tick));

endmodule

bind vga_upscale_scanout vgs_scanout_checker #(
    .HCW      (HCW),
    .VCW      (VCW),
    .H_TOTAL  (H_TOTAL),
    .V_TOTAL  (V_TOTAL),
    .V_ACTIVE (V_ACTIVE)
) u_scanout_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_ce     (pix_ce),
    .h_cnt      (h_cnt),
    .v_cnt      (v_cnt),
    .vga_hs_n   (vga_hs_n),
    .vga_vs_n   (vga_vs_n),
    .rgb        ({vga_red, vga_grn, vga_blu}),
    .frame_tick (frame_tick)
);

// File: tb/tb_vga_upscale_scanout.sv
`timescale 1ns/1ps
module tb_vga_upscale_scanout;

    // Shrunk raster: window 32x16 inside a 40x20 visible area.
    localparam int HA = 40, HF = 4, HS = 6, HB = 6;
    localparam int VA = 20, VF = 2, VS = 3, VB = 3;
    localparam int FBX = 3, FBY = 2, SC = 2;
    localparam int HT = HA + HF + HS + HB;     // 56
    localparam int VT = VA + VF + VS + VB;     // 28
    localparam int FRAME = HT * VT;            // 1568
    localparam int WIN_W = 1 << (FBX + SC);    // 32
    localparam int WIN_H = 1 << (FBY + SC);    // 16
    localparam int TICK_N = HT * VA + FRAME;   // first tick, frame 1

    localparam logic [1:0] C_PIX = 2'd0, C_DARK = 2'd1, C_HSY = 2'd2, C_VSY = 2'd3;
    localparam int NPROBE = 22;
    // {column(8), line(8), class(2)}, in scan order of frame 0
    localparam logic [17:0] PROBES [NPROBE] = '{
        {8'd0,  8'd0,  C_PIX},  {8'd3,  8'd0,  C_PIX},  {8'd4,  8'd0,  C_PIX},
        {8'd32, 8'd0,  C_DARK}, {8'd40, 8'd0,  C_DARK}, {8'd44, 8'd0,  C_HSY},
        {8'd49, 8'd0,  C_HSY},  {8'd50, 8'd0,  C_DARK}, {8'd55, 8'd0,  C_DARK},
        {8'd31, 8'd3,  C_PIX},  {8'd4,  8'd4,  C_PIX},  {8'd7,  8'd7,  C_PIX},
        {8'd39, 8'd7,  C_DARK}, {8'd44, 8'd12, C_HSY},  {8'd31, 8'd15, C_PIX},
        {8'd0,  8'd16, C_DARK}, {8'd47, 8'd17, C_HSY},  {8'd10, 8'd19, C_DARK},
        {8'd0,  8'd21, C_DARK}, {8'd45, 8'd21, C_HSY},  {8'd0,  8'd22, C_VSY},
        {8'd30, 8'd24, C_VSY}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pix_ce = 1'b0;
    logic [FBX+FBY-1:0] fb_addr;
    logic [11:0]      fb_data;
    logic [3:0]       vga_red, vga_grn, vga_blu;
    logic             vga_hs_n, vga_vs_n, frame_tick;

    int tests = 0;
    int fails = 0;
    int n = 0;
    logic tick_exp = 1'b0;
    bit cmp_en = 1'b0;
    int mm_sync = 0, mm_pix = 0, mm_tick = 0, ticks = 0;

    always #2 clk = ~clk;

    vga_upscale_scanout #(
        .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .FB_XW(FBX), .FB_YW(FBY), .SCALE_LOG2(SC),
        .FETCH_LAT(1), .RATE_DIV(2)
    ) dut (
        .clk(clk), .rst(rst), .pix_ce(pix_ce), .fb_addr(fb_addr), .fb_data(fb_data),
        .vga_red(vga_red), .vga_grn(vga_grn), .vga_blu(vga_blu),
        .vga_hs_n(vga_hs_n), .vga_vs_n(vga_vs_n), .frame_tick(frame_tick)
    );

    function automatic logic [11:0] pat(input int a);
        return 12'(a * 397 + 91);
    endfunction

    function automatic int addr_of(input int h, input int v);
        return ((v >> SC) << FBX) | (h >> SC);
    endfunction

    // Expected {hs_n, vs_n, colour} after n enabled edges since reset.
    function automatic logic [13:0] model(input int nn);
        int p, h, v;
        logic hs, vs;
        logic [11:0] c;
        if (nn < 2) return {1'b1, 1'b1, 12'h000};
        p = (nn - 2) % FRAME;
        h = p % HT;
        v = p / HT;
        hs = !(h >= HA + HF && h < HA + HF + HS);
        vs = !(v >= VA + VF && v < VA + VF + VS);
        c = (h < WIN_W && v < WIN_H) ? pat(addr_of(h, v)) : 12'h000;
        return {hs, vs, c};
    endfunction

    // Synchronous image memory, one enabled edge of latency.
    always @(posedge clk) begin
        if (pix_ce) fb_data <= pat(int'(fb_addr));
    end

    always @(posedge clk) begin
        tick_exp <= !rst && pix_ce && (((n + 1) % (2 * FRAME)) == TICK_N);
        if (rst)         n <= 0;
        else if (pix_ce) n <= n + 1;
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            logic [13:0] e;
            e = model(n);
            if ({vga_hs_n, vga_vs_n} !== e[13:12]) mm_sync++;
            if ({vga_red, vga_grn, vga_blu} !== e[11:0]) mm_pix++;
            if (frame_tick !== tick_exp) mm_tick++;
            if (frame_tick) ticks++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic ce);
        pix_ce = ce;
        @(negedge clk);
    endtask

    task automatic run_to(input int target);
        while (n < target) step(1'b1);
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " R8 hs_n"}, int'(vga_hs_n), 1);
        chk({tag, " R8 vs_n"}, int'(vga_vs_n), 1);
        chk({tag, " R8 colour"}, int'({vga_red, vga_grn, vga_blu}), 0);
        chk({tag, " R8 frame_tick"}, int'(frame_tick), 0);
        chk({tag, " R8 fb_addr"}, int'(fb_addr), 0);
    endtask

    task automatic run_all();
        int hold_addr, hold_col, hold_sync;
        @(negedge clk);
        pix_ce = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state("initial reset");
        rst = 1'b0;
        cmp_en = 1'b1;

        // Table walk over frame 0 (R1..R5).
        for (int i = 0; i < NPROBE; i++) begin
            int ph, pv, pc;
            ph = int'(PROBES[i][17:10]);
            pv = int'(PROBES[i][9:2]);
            pc = int'(PROBES[i][1:0]);
            run_to(pv * HT + ph + 2);
            case (pc)
                0: begin
                    chk($sformatf("R3 R4 colour at %0d,%0d", ph, pv),
                        int'({vga_red, vga_grn, vga_blu}), int'(pat(addr_of(ph, pv))));
                    chk($sformatf("R3 syncs at %0d,%0d", ph, pv), int'({vga_hs_n, vga_vs_n}), 3);
                end
                1: begin
                    chk($sformatf("R5 black at %0d,%0d", ph, pv), int'({vga_red, vga_grn, vga_blu}), 0);
                    chk($sformatf("R1 R2 syncs idle at %0d,%0d", ph, pv), int'({vga_hs_n, vga_vs_n}), 3);
                end
                2: begin
                    chk($sformatf("R1 hsync low at %0d,%0d", ph, pv), int'({vga_hs_n, vga_vs_n}), 1);
                    chk($sformatf("R5 black in hsync at %0d,%0d", ph, pv), int'({vga_red, vga_grn, vga_blu}), 0);
                end
                default: begin
                    chk($sformatf("R2 vsync low at %0d,%0d", ph, pv), int'({vga_hs_n, vga_vs_n}), 2);
                    chk($sformatf("R5 black in vsync at %0d,%0d", ph, pv), int'({vga_red, vga_grn, vga_blu}), 0);
                end
            endcase
        end

        // First frame end: no tick yet (R6).
        run_to(HT * VA);
        chk("R6 no tick on frame 0", ticks, 0);
        run_to(TICK_N - 1);
        step(1'b1);
        chk("R6 tick at frame 1 blanking start", int'(frame_tick), 1);
        step(1'b1);
        chk("R6 tick lasts one clock", int'(frame_tick), 0);

        run_to(4 * FRAME + 2);
        chk("R1 R2 sync mismatches over four frames", mm_sync, 0);
        chk("R3 R4 R5 colour mismatches over four frames", mm_pix, 0);
        chk("R6 tick mismatches over four frames", mm_tick, 0);
        chk("R6 two ticks in four frames", ticks, 2);

        // Enable held low: everything freezes (R7).
        run_to(4 * FRAME + 3 * HT + 5);
        hold_addr = int'(fb_addr);
        hold_col  = int'({vga_red, vga_grn, vga_blu});
        hold_sync = int'({vga_hs_n, vga_vs_n});
        repeat (6) step(1'b0);
        chk("R7 fb_addr held", int'(fb_addr), hold_addr);
        chk("R7 colour held", int'({vga_red, vga_grn, vga_blu}), hold_col);
        chk("R7 syncs held", int'({vga_hs_n, vga_vs_n}), hold_sync);

        // Alternate enable across the frame-5 tick.
        while (n < 5 * FRAME + HT * VA + 10) begin
            step(1'b1);
            step(1'b0);
        end
        chk("R7 gated run mismatches", mm_sync + mm_pix + mm_tick, 0);
        chk("R6 R7 tick under gated enable", ticks, 3);

        // Mid-frame reset (R8).
        run_to(5 * FRAME + HT * VA + 200);
        rst = 1'b1;
        repeat (3) step(1'b1);
        check_reset_state("mid-frame reset");
        rst = 1'b0;
        run_to(HT * VA + 5);
        chk("R8 pairing restarts, frame 0 silent", ticks, 3);
        run_to(2 * FRAME + 2);
        chk("R8 tick after reset at frame 1", ticks, 4);
        chk("R8 post-reset mismatches", mm_sync + mm_pix + mm_tick, 0);
        cmp_en = 1'b0;
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule